// File: doc/BRIEF.md
# Burst Column Address Sequencer with Mode Register

This block sits beside the command path of a synchronous DRAM controller model. It keeps a 13-bit mode word, which a mode-load strobe writes only while the two bank-select inputs are both zero. A read or write command carries a starting column. From the next clock on, the block emits one column address per cycle until the burst is complete. The burst length and ordering come from the mode word, and a stop input can end the burst early.

The column order stays inside an aligned block whose size is the burst length. The bits above that block stay fixed. The low bits either count upward and wrap (sequential) or take the start XORed with a running count (interleaved). A full-page burst counts through all 2^COL_W columns and keeps going until it is stopped or replaced. A mode bit can make every write a single access while reads still burst. The decoded CAS latency and the write mode are driven out for the logic that moves data, which this block does not do.

Top module: `burst_col_seq`

## Requirements
- R1: After reset no column is valid and the mode word is 0x020: length 1, sequential, latency 2, burst writes. The error flag is clear.
- R2: A mode load with bank_sel equal to 0 and a legal word takes effect on the outputs from the next cycle. A mode load with any other bank_sel value leaves the mode word and the error flag unchanged.
- R3: A mode word is illegal in any of these cases. Bits 2:0 are not 000, 001, 010, 011 or 111. Bits 2:0 are 111 while bit 3 is 1. Bits 6:4 are not 010 or 011. Bits 8:7 are not 00. Bits 12:10 are not 000. Loading an illegal word sets mode_err and keeps the previous word. Only reset clears mode_err.
- R4: cas_lat gives the latency as a number: 2 when bits 6:4 are 010, 3 when they are 011. wr_single equals bit 9.
- R5: Bits 2:0 set the burst length: 000 gives 1, 001 gives 2, 010 gives 4, 011 gives 8, 111 gives full page. A command sampled at clock edge k makes the start column appear on col with col_valid high after edge k. One further column follows per cycle.
- R6: When bit 3 is 0 and the length N is 2, 4 or 8, column i of the burst is (start + i) mod N in the low log2(N) bits. The upper bits keep the value of the start column.
- R7: When bit 3 is 1, the low log2(N) bits of column i are start XOR i.
- R8: A full-page burst emits start, start+1, and so on, modulo 2^COL_W. It runs until a stop or a new command, and col_last stays low during it.
- R9: col_last is high only together with the final column of a fixed-length burst. In the cycle after it, col_valid is low unless a new command arrived.
- R10: A stop_req sampled during a burst makes col_valid low from the next cycle. A stop_req with no burst running has no effect.
- R11: A command sampled during a burst restarts the sequence from its own start column on the next cycle. A command wins over a stop_req in the same cycle. If read and write are both raised together, the command is treated as a read.
- R12: When bit 9 is 1, a write yields a single column with col_last high, and reads still use the programmed length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mrs_stb | input | 1 | Mode-load strobe |
| bank_sel | input | 2 | Bank select; a mode load happens only when this is 0 |
| mode_in | input | 13 | Mode word to load |
| cmd_rd | input | 1 | Read command |
| cmd_wr | input | 1 | Write command |
| start_col | input | COL_W | Starting column of the command |
| stop_req | input | 1 | Burst stop |
| col | output | COL_W | Current column address |
| col_valid | output | 1 | col holds a burst column |
| col_last | output | 1 | Final column of a fixed-length burst |
| cas_lat | output | 2 | Decoded CAS latency (2 or 3) |
| wr_single | output | 1 | Writes are single-access |
| mode_err | output | 1 | Sticky flag for an illegal mode load |

## Verification
The assertions assume that the upper column bits can only change when a command arrives. They also assume that no mode word with full page and interleave together is ever stored, because R3 rejects it. The stimulus therefore sends that combination only as a rejected load. Commands and stops are applied in cycles chosen so that each case is isolated: mid-burst, on the last column, while idle, and together in the same cycle. The order and length of every burst are recomputed from the mode word that the bench model holds.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
    localparam int MODE_W = 13;
    localparam int BL_W   = 3;
    localparam int CL_W   = 2;

    typedef enum logic [BL_W-1:0] {
        BLEN_1    = 3'b000,
        BLEN_2    = 3'b001,
        BLEN_4    = 3'b010,
        BLEN_8    = 3'b011,
        BLEN_PAGE = 3'b111
    } blen_e;

    localparam logic [MODE_W-1:0] MODE_RST = 13'h020;

    typedef struct packed {
        logic [MODE_W-1:0] word;
        logic              err;
    } mreg_t;

    function automatic logic mode_legal(input logic [MODE_W-1:0] w);
        logic ok;
        ok = 1'b1;
        case (w[2:0])
            BLEN_1, BLEN_2, BLEN_4, BLEN_8: ok = 1'b1;
            BLEN_PAGE: if (w[3]) ok = 1'b0;
            default:   ok = 1'b0;
        endcase
        if (w[6:4] != 3'b010 && w[6:4] != 3'b011) ok = 1'b0;
        if (w[8:7] != 2'b00) ok = 1'b0;
        if (w[12:10] != 3'b000) ok = 1'b0;
        return ok;
    endfunction
endpackage

// File: rtl/bcs_mode_reg.sv
module bcs_mode_reg
    import bcs_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [1:0]           bank_sel,
    input  logic [MODE_W-1:0]    wr_data,
    output logic [BL_W-1:0]      bl_code,
    output logic                 ilv,
    output logic [CL_W-1:0]      cas_lat,
    output logic                 wr_single,
    output logic                 err
);
    mreg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en && bank_sel == 2'b00) begin
            if (mode_legal(wr_data)) st_d.word = wr_data;
            else                     st_d.err  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{word: MODE_RST, err: 1'b0};
        else        st_q <= st_d;
    end

    assign bl_code   = st_q.word[2:0];
    assign ilv       = st_q.word[3];
    assign cas_lat   = st_q.word[5:4];
    assign wr_single = st_q.word[9];
    assign err       = st_q.err;

    // R3: error flag only clears through reset
    a_r3_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);
    // R3: an illegal load keeps the previous word
    a_r3_bad_keeps_word: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bank_sel == 2'b00 && !mode_legal(wr_data)) |=> $stable(st_q.word));
    // R2: loads aimed at other banks touch nothing
    a_r2_other_bank: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bank_sel != 2'b00) |=> $stable(st_q));
endmodule

// File: rtl/bcs_col_gen.sv
module bcs_col_gen
    import bcs_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_rd,
    input  logic                 cmd_wr,
    input  logic [COL_W-1:0]     start_col,
    input  logic                 stop_req,
    input  logic [BL_W-1:0]      bl_code,
    input  logic                 ilv,
    input  logic                 wr_single,
    output logic [COL_W-1:0]     col,
    output logic                 col_valid,
    output logic                 col_last
);
    typedef struct packed {
        logic             act;
        logic             full;
        logic             ilv;
        logic [COL_W-1:0] base;
        logic [COL_W-1:0] cnt;
        logic [COL_W-1:0] mask;
    } seq_t;

    seq_t st_d, st_q;
    logic             cmd_any;
    logic             one_shot;
    logic [COL_W-1:0] new_mask;
    logic [COL_W-1:0] low_seq, low_ilv;

    assign cmd_any  = cmd_rd | cmd_wr;
    assign one_shot = cmd_wr && !cmd_rd && wr_single;

    always_comb begin
        case (bl_code)
            BLEN_1:  new_mask = COL_W'(0);
            BLEN_2:  new_mask = COL_W'(1);
            BLEN_4:  new_mask = COL_W'(3);
            BLEN_8:  new_mask = COL_W'(7);
            default: new_mask = '1;
        endcase
        if (one_shot) new_mask = COL_W'(0);
    end

    assign low_seq   = (st_q.base + st_q.cnt) & st_q.mask;
    assign low_ilv   = (st_q.base ^ st_q.cnt) & st_q.mask;
    assign col       = (st_q.base & ~st_q.mask) | (st_q.ilv ? low_ilv : low_seq);
    assign col_valid = st_q.act;
    assign col_last  = st_q.act && !st_q.full && (st_q.cnt == st_q.mask);

    always_comb begin
        st_d = st_q;
        if (cmd_any) begin
            st_d.act  = 1'b1;
            st_d.full = (bl_code == BLEN_PAGE) && !one_shot;
            st_d.ilv  = ilv && !((bl_code == BLEN_PAGE) && !one_shot);
            st_d.base = start_col;
            st_d.cnt  = '0;
            st_d.mask = new_mask;
        end else if (st_q.act) begin
            if (stop_req || col_last) st_d.act = 1'b0;
            else                      st_d.cnt = st_q.cnt + COL_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5: a command shows its start column on the next cycle
    a_r5_first_col: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_any |=> (col_valid && col == $past(start_col)));
    // R10: a stop ends the burst at once
    a_r10_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && stop_req && !cmd_any) |=> !col_valid);
    // R9: nothing follows the final column
    a_r9_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (col_last && !cmd_any) |=> !col_valid);
    // R6: upper column bits stay fixed inside a burst
    a_r6_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && !col_last && !stop_req && !cmd_any) |=>
        (col_valid && ((col ^ $past(col)) & ~st_q.mask) == '0));
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import bcs_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mrs_stb,
    input  logic [1:0]         bank_sel,
    input  logic [12:0]        mode_in,
    input  logic               cmd_rd,
    input  logic               cmd_wr,
    input  logic [COL_W-1:0]   start_col,
    input  logic               stop_req,
    output logic [COL_W-1:0]   col,
    output logic               col_valid,
    output logic               col_last,
    output logic [1:0]         cas_lat,
    output logic               wr_single,
    output logic               mode_err
);
    logic [BL_W-1:0] bl_code;
    logic            ilv;

    bcs_mode_reg u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (mrs_stb),
        .bank_sel  (bank_sel),
        .wr_data   (mode_in),
        .bl_code   (bl_code),
        .ilv       (ilv),
        .cas_lat   (cas_lat),
        .wr_single (wr_single),
        .err       (mode_err)
    );

    bcs_col_gen #(.COL_W(COL_W)) u_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_rd    (cmd_rd),
        .cmd_wr    (cmd_wr),
        .start_col (start_col),
        .stop_req  (stop_req),
        .bl_code   (bl_code),
        .ilv       (ilv),
        .wr_single (wr_single),
        .col       (col),
        .col_valid (col_valid),
        .col_last  (col_last)
    );

    // R9: the last flag never stands alone
    a_r9_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
        col_last |-> col_valid);
endmodule

// File: tb/sim_burst_col_seq.sv
module sim_burst_col_seq;
    localparam int CLK_P = 10;
    localparam int COL_W = 9;
    localparam int NCOL  = 1 << COL_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             mrs_stb = 1'b0;
    logic [1:0]       bank_sel = 2'b00;
    logic [12:0]      mode_in = '0;
    logic             cmd_rd = 1'b0, cmd_wr = 1'b0;
    logic [COL_W-1:0] start_col = '0;
    logic             stop_req = 1'b0;
    logic [COL_W-1:0] col;
    logic             col_valid, col_last, wr_single, mode_err;
    logic [1:0]       cas_lat;

    int    n_run = 0, n_fail = 0;
    string ph = "R1";

    burst_col_seq #(.COL_W(COL_W)) u0 (
        .clk(clk), .rst_n(rst_n), .mrs_stb(mrs_stb), .bank_sel(bank_sel),
        .mode_in(mode_in), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr),
        .start_col(start_col), .stop_req(stop_req), .col(col),
        .col_valid(col_valid), .col_last(col_last), .cas_lat(cas_lat),
        .wr_single(wr_single), .mode_err(mode_err)
    );

    always #(CLK_P/2) clk = ~clk;

    // behavioural reference model
    logic [12:0] m_mode;
    bit          m_err;
    int          exp_q[$];
    bit          fp;
    int          fp_col;

    function automatic bit legal(input logic [12:0] w);
        int len_ok, cl_ok;
        len_ok = (w[2:0] <= 3) || (w[2:0] == 7 && w[3] == 0);
        cl_ok  = (w[6:4] == 2) || (w[6:4] == 3);
        return len_ok && cl_ok && w[8:7] == 0 && w[12:10] == 0;
    endfunction

    function automatic int blen(input logic [2:0] c);
        if (c == 7) return 0;
        return 1 << c;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 13'h020; m_err = 0; exp_q.delete(); fp = 0; fp_col = 0;
        end else begin
            if (cmd_rd || cmd_wr) begin
                int n;
                exp_q.delete(); fp = 0;
                n = blen(m_mode[2:0]);
                if (cmd_wr && !cmd_rd && m_mode[9]) n = 1;
                if (n == 0) begin
                    fp = 1; fp_col = int'(start_col);
                end else begin
                    for (int i = 0; i < n; i++) begin
                        int s, lo;
                        s = int'(start_col);
                        if (m_mode[3]) lo = (s % n) ^ i;
                        else           lo = ((s % n) + i) % n;
                        exp_q.push_back(s - (s % n) + lo);
                    end
                end
            end else if (stop_req) begin
                exp_q.delete(); fp = 0;
            end else if (fp) begin
                fp_col = (fp_col + 1) % NCOL;
            end else if (exp_q.size() > 0) begin
                void'(exp_q.pop_front());
            end
            if (mrs_stb && bank_sel == 0) begin
                if (legal(mode_in)) m_mode = mode_in;
                else                m_err = 1;
            end
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n || ph == "R1") begin
            bit ev;
            ev = fp || exp_q.size() > 0;
            check(ph, "col_valid", int'(col_valid), int'(ev));
            if (ev) check(ph, "col", int'(col), fp ? fp_col : exp_q[0]);
            check("R9", "col_last", int'(col_last), int'(!fp && exp_q.size() == 1));
            check(ph == "R2" ? "R2" : "R4", "cas_lat", int'(cas_lat), m_mode[6:4] == 3 ? 3 : 2);
            check(ph == "R12" ? "R12" : "R4", "wr_single", int'(wr_single), int'(m_mode[9]));
            check(ph == "R2" ? "R2" : "R3", "mode_err", int'(mode_err), int'(m_err));
        end
    end

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic idle(input int k);
        repeat (k) step();
    endtask

    task automatic load(input logic [1:0] b, input logic [12:0] v);
        step(); mrs_stb = 1; bank_sel = b; mode_in = v;
        step(); mrs_stb = 0; bank_sel = 0;
    endtask

    task automatic issue(input bit rd, input bit wr, input int c, input bit stp);
        step(); cmd_rd = rd; cmd_wr = wr; start_col = COL_W'(c); stop_req = stp;
        step(); cmd_rd = 0; cmd_wr = 0; stop_req = 0;
    endtask

    task automatic stop_now();
        stop_req = 1; step(); stop_req = 0;
    endtask

    initial begin
        #(CLK_P * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        ph = "R1";
        idle(3);
        rst_n = 1;
        idle(2);
        ph = "R5";
        issue(1, 0, 5, 0); idle(3);
        ph = "R2";
        load(2'b01, 13'h033); idle(2);
        load(2'b10, 13'h2A3); idle(2);
        ph = "R4";
        load(2'b00, 13'h031); idle(1);
        issue(1, 0, 7, 0); idle(3);
        ph = "R6";
        load(2'b00, 13'h023);
        issue(1, 0, 13, 0); idle(9);
        load(2'b00, 13'h022);
        issue(0, 1, 30, 0); idle(5);
        ph = "R7";
        load(2'b00, 13'h02B);
        issue(1, 0, 5, 0); idle(9);
        load(2'b00, 13'h02A);
        issue(1, 0, 31, 0); idle(5);
        ph = "R8";
        load(2'b00, 13'h037);
        issue(1, 0, 509, 0); idle(10);
        stop_now(); idle(2);
        ph = "R10";
        load(2'b00, 13'h023);
        issue(1, 0, 2, 0); idle(2);
        stop_now(); idle(3);
        stop_now(); idle(2);
        ph = "R11";
        issue(1, 0, 40, 0); idle(2);
        issue(0, 1, 17, 0); idle(3);
        issue(1, 0, 100, 1); idle(9);
        issue(1, 1, 64, 0); idle(9);
        ph = "R12";
        load(2'b00, 13'h223);
        issue(0, 1, 3, 0); idle(2);
        issue(1, 0, 3, 0); idle(9);
        issue(0, 1, 11, 0); idle(2);
        ph = "R3";
        load(2'b00, 13'h024); idle(1);
        load(2'b00, 13'h02F); idle(1);
        load(2'b00, 13'h043); idle(1);
        load(2'b00, 13'h0A3); idle(1);
        load(2'b00, 13'h423); idle(1);
        issue(1, 0, 6, 0); idle(9);
        load(2'b00, 13'h032); idle(2);
        issue(1, 0, 9, 0); idle(5);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule